// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small 8-bit accumulator machine. Every instruction starts with a fetch micro-word stored at micro-address 0. That word loads the instruction byte and bumps the program counter. The sequencer then splits the byte into two parts. The top six bits are the opcode and select a micro-routine. The bottom two bits name a working register and are held on `reg_sel` for the datapath. Each opcode owns a slot of eight consecutive micro-words, starting at opcode × 8. A routine longer than one slot may also use the slot that follows it.

A micro-program counter (uPC) walks the routine and reads one 32-bit control word per step from an internal ROM. The two most significant bits of that word tell the sequencer where to go next. Every routine ends with an interrupt poll. If no interrupt is due, the uPC returns to fetch. If an interrupt is due, three acknowledge words run and the last of them returns to fetch. Unused words inside a slot hold a padding word that also returns to fetch.

In run mode the uPC moves on every clock. In single-step mode it moves only in a cycle where the step strobe is high. The ROM holds a small test program: fetch, a register-add (opcode 3), a move-immediate (opcode 8) and a two-slot long routine (opcode 12). Every other opcode gets a bare poll-and-acknowledge tail.

Top module: `micro_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `upc` becomes 0 and `reg_sel` becomes 0. This includes an edge where the current word is a decode word, and `ctrl_word` then shows the fetch word.
- R2: The control word's sequencing field is bits [31:30]: 00 step, 01 decode, 10 return to fetch, 11 interrupt poll. The low bits are datapath strobes: bit0 PC increment, bit1 IR load, bit2 operand read, bit3 register write, bit4 add, bit5 flag write, bit6 ack-1, bit7 ack-2, bit8 end-of-interrupt, bit9 long-op. The fetch word at uPC 0 is 32'h4000_0003.
- R3: When the uPC advances on a decode word, it loads instruction bits [7:2] × 8, so byte 20h goes to word 64, which is byte address 100h. `reg_sel` loads bits [1:0] and holds them until the next decode.
- R4: A step word moves the uPC on by one. This holds across the boundary between the two slots of the long routine (words 96–107 carry 32'h0000_0200). Opcode 8 runs 32'h0000_0005 then 32'h0000_0008. Opcode 3 runs 32'h0000_0030.
- R5: A return-to-fetch word sends the uPC to 0.
- R6: A poll word is 32'hC000_0000. If `irq_pending` and `irq_allow` are both high, the uPC moves to the next word. The next three words are 32'h0000_0040, 32'h0000_0080 and 32'h8000_0100. If either input is low, the uPC goes to 0.
- R7: With `step_mode` high, the uPC and `reg_sel` change only in cycles where `step_go` is high. A poll is decided on the interrupt inputs of that strobed cycle. With `step_mode` low, the uPC advances every cycle.
- R8: An instruction byte with opcode 0 decodes back to uPC 0, so the fetch runs again.
- R9: An opcode with no routine enters directly at its poll word (opcode 31 gives word 248).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_byte | input | 8 | Instruction byte from memory, sampled on the decode step |
| irq_pending | input | 1 | An interrupt request is waiting |
| irq_allow | input | 1 | Interrupts are enabled |
| step_mode | input | 1 | 1 = single-step, 0 = run |
| step_go | input | 1 | One-cycle step strobe, used in single-step mode |
| ctrl_word | output | 32 | Control word at the current uPC |
| upc | output | 9 | Micro-program counter |
| reg_sel | output | 2 | Register field of the last decoded instruction |

## Verification
The two functions that can fall in the same cycle are the step gate and a sequencing decision. Either can meet a poll or a decode. The bench provokes this by parking the uPC on a poll word in single-step mode with an interrupt pending and the strobe low, then dropping the request in the cycle the strobe fires. The uPC must return to fetch, which shows the decision follows only the strobed cycle. The bench also asserts reset on the edge where a decode word is live, and expects the fetch state with `reg_sel` cleared. A scoreboard holds the expected uPC, control word and register field for every edge and compares them half a cycle later.

// File: rtl/useq_pkg.sv
// Package: shared types, control-word encodings and the computed microcode
// image of the control sequencer.
// Assumes a 32-bit control word whose top two bits carry the sequencing code.
package useq_pkg;

    typedef enum logic [1:0] {
        SEQ_STEP    = 2'b00,
        SEQ_DECODE  = 2'b01,
        SEQ_RESTART = 2'b10,
        SEQ_POLL    = 2'b11
    } seq_e;

    // sequencing codes placed in bits [31:30]
    localparam logic [31:0] SQ_DECODE  = 32'h4000_0000;
    localparam logic [31:0] SQ_RESTART = 32'h8000_0000;
    localparam logic [31:0] SQ_POLL    = 32'hC000_0000;

    // datapath strobes
    localparam logic [31:0] CB_PC_INC  = 32'h0000_0001;
    localparam logic [31:0] CB_IR_LOAD = 32'h0000_0002;
    localparam logic [31:0] CB_OPND_RD = 32'h0000_0004;
    localparam logic [31:0] CB_REG_WR  = 32'h0000_0008;
    localparam logic [31:0] CB_ALU_ADD = 32'h0000_0010;
    localparam logic [31:0] CB_FLAG_WR = 32'h0000_0020;
    localparam logic [31:0] CB_INTA1   = 32'h0000_0040;
    localparam logic [31:0] CB_INTA2   = 32'h0000_0080;
    localparam logic [31:0] CB_EOI     = 32'h0000_0100;
    localparam logic [31:0] CB_LONG    = 32'h0000_0200;

    // assembled words
    localparam logic [31:0] W_FETCH = SQ_DECODE | CB_IR_LOAD | CB_PC_INC;
    localparam logic [31:0] W_PAD   = SQ_RESTART;
    localparam logic [31:0] W_ADD   = CB_ALU_ADD | CB_FLAG_WR;
    localparam logic [31:0] W_MOVI0 = CB_PC_INC | CB_OPND_RD;
    localparam logic [31:0] W_MOVI1 = CB_REG_WR;
    localparam logic [31:0] W_LONG  = CB_LONG;

    // opcodes of the test program
    localparam int OP_FETCH = 0;
    localparam int OP_ADD   = 3;
    localparam int OP_MOVI  = 8;
    localparam int OP_LONG  = 12;

    // Interrupt tail: poll, two acknowledges, end-of-interrupt with return.
    function automatic logic [31:0] tail_word(input int k);
        logic [31:0] w;
        case (k)
            0:       w = SQ_POLL;
            1:       w = CB_INTA1;
            2:       w = CB_INTA2;
            3:       w = SQ_RESTART | CB_EOI;
            default: w = W_PAD;
        endcase
        return w;
    endfunction

    // Control word stored at micro-address addr for a slot of stride words.
    function automatic logic [31:0] ucode_word(input int addr, input int stride);
        int opc;
        int off;
        int loc;
        int long_body;
        logic [31:0] w;
        opc       = addr / stride;
        off       = addr % stride;
        loc       = addr - OP_LONG * stride;
        long_body = 2 * stride - 4;
        if (opc == OP_FETCH) begin
            w = (off == 0) ? W_FETCH : W_PAD;
        end else if (opc == OP_ADD) begin
            w = (off == 0) ? W_ADD : tail_word(off - 1);
        end else if (opc == OP_MOVI) begin
            if (off == 0)      w = W_MOVI0;
            else if (off == 1) w = W_MOVI1;
            else               w = tail_word(off - 2);
        end else if (opc == OP_LONG || opc == OP_LONG + 1) begin
            w = (loc < long_body) ? W_LONG : tail_word(loc - long_body);
        end else begin
            w = tail_word(off);
        end
        return w;
    endfunction

endpackage

// File: rtl/useq_rom.sv
// Module: control store. Combinational read of the computed microcode image.
// Assumes CW_W is 32; the image is produced by the package function.
module useq_rom #(
    parameter int UPC_W     = 9,
    parameter int STRIDE_LG = 3,
    parameter int CW_W      = 32
) (
    input  logic [UPC_W-1:0] addr,
    output logic [CW_W-1:0]  word
);
    import useq_pkg::*;

    localparam int STRIDE = 1 << STRIDE_LG;

    // purpose: look up the word at the current micro-address
    always_comb begin
        word = CW_W'(ucode_word(int'(addr), STRIDE));
    end

endmodule

// File: rtl/useq_next.sv
// Module: next micro-address selection.
// Picks between increment, opcode entry, return to fetch and the poll branch.
// Assumes each opcode slot is 2**STRIDE_LG words long.
module useq_next #(
    parameter int OPC_W     = 6,
    parameter int STRIDE_LG = 3,
    localparam int UPC_W    = OPC_W + STRIDE_LG
) (
    input  logic [UPC_W-1:0] upc,
    input  useq_pkg::seq_e   seq,
    input  logic [OPC_W-1:0] opcode,
    input  logic             irq_go,
    output logic [UPC_W-1:0] upc_nxt
);
    import useq_pkg::*;

    // purpose: choose the following micro-address from the sequencing code
    always_comb begin
        case (seq)
            SEQ_DECODE:  upc_nxt = {opcode, {STRIDE_LG{1'b0}}};
            SEQ_RESTART: upc_nxt = '0;
            SEQ_POLL:    upc_nxt = irq_go ? upc + UPC_W'(1) : '0;
            default:     upc_nxt = upc + UPC_W'(1);
        endcase
    end

endmodule

// File: rtl/micro_sequencer.sv
// Module: top of the microprogrammed control sequencer.
// Holds the uPC and the latched register field, and gates advance by the
// single-step strobe. Assumes the instruction byte is valid in the cycle
// whose control word carries the decode code.
module micro_sequencer #(
    parameter int IR_W      = 8,
    parameter int OPC_W     = 6,
    parameter int STRIDE_LG = 3,
    parameter int CW_W      = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IR_W-1:0]              instr_byte,
    input  logic                         irq_pending,
    input  logic                         irq_allow,
    input  logic                         step_mode,
    input  logic                         step_go,
    output logic [CW_W-1:0]              ctrl_word,
    output logic [OPC_W+STRIDE_LG-1:0]   upc,
    output logic [IR_W-OPC_W-1:0]        reg_sel
);
    import useq_pkg::*;

    localparam int UPC_W = OPC_W + STRIDE_LG;
    localparam int REG_W = IR_W - OPC_W;

    logic             adv;
    logic             irq_go;
    logic             take_decode;
    seq_e             seq;
    logic [UPC_W-1:0] upc_nxt;
    logic [OPC_W-1:0] opcode;

    assign adv         = !step_mode || step_go;
    assign irq_go      = irq_pending && irq_allow;
    assign seq         = seq_e'(ctrl_word[CW_W-1 -: 2]);
    assign opcode      = instr_byte[IR_W-1 -: OPC_W];
    assign take_decode = adv && (seq == SEQ_DECODE);

    useq_rom #(
        .UPC_W     (UPC_W),
        .STRIDE_LG (STRIDE_LG),
        .CW_W      (CW_W)
    ) u_rom (
        .addr (upc),
        .word (ctrl_word)
    );

    useq_next #(
        .OPC_W     (OPC_W),
        .STRIDE_LG (STRIDE_LG)
    ) u_next (
        .upc     (upc),
        .seq     (seq),
        .opcode  (opcode),
        .irq_go  (irq_go),
        .upc_nxt (upc_nxt)
    );

    // purpose: micro-program counter, advanced when run mode or a step strobe allows
    always_ff @(posedge clk) begin
        if (!rst_n)   upc <= '0;
        else if (adv) upc <= upc_nxt;
    end

    // purpose: capture the register field on each taken decode
    always_ff @(posedge clk) begin
        if (!rst_n)           reg_sel <= '0;
        else if (take_decode) reg_sel <= instr_byte[REG_W-1:0];
    end

    // R3: a taken decode lands on the opcode's slot base
    p_decode_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_decode |=> (upc == {$past(opcode), {STRIDE_LG{1'b0}}}));

    // R3: register field only changes on a taken decode
    p_regsel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !take_decode |=> $stable(reg_sel));

    // R4: a step word moves the uPC by exactly one
    p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && seq == SEQ_STEP) |=> (upc == $past(upc) + UPC_W'(1)));

    // R5: a return word goes back to fetch
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && seq == SEQ_RESTART) |=> (upc == '0));

    // R6: a poll with nothing to take goes back to fetch
    p_poll_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && seq == SEQ_POLL && !irq_go) |=> (upc == '0));

    // R7: without a strobe in single-step mode nothing moves
    p_step_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_mode && !step_go) |=> ($stable(upc) && $stable(reg_sel)));

endmodule

// File: tb/micro_sequencer_tb.sv
// Scoreboard bench: the driver queues the expected state after each edge,
// and the monitor compares it on the following falling edge.
module micro_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] instr = 8'h00;
    logic       irq_pend = 1'b0;
    logic       irq_allow = 1'b0;
    logic       step_mode = 1'b0;
    logic       step_go = 1'b0;
    logic [31:0] ctrl_word;
    logic [8:0]  upc;
    logic [1:0]  reg_sel;

    localparam logic [31:0] FETCH = 32'h4000_0003;
    localparam logic [31:0] POLL  = 32'hC000_0000;
    localparam logic [31:0] ACK1  = 32'h0000_0040;
    localparam logic [31:0] ACK2  = 32'h0000_0080;
    localparam logic [31:0] ACK3  = 32'h8000_0100;
    localparam logic [31:0] LONGW = 32'h0000_0200;

    typedef struct {
        logic [8:0]  u;
        logic [31:0] c;
        logic [1:0]  r;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    micro_sequencer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_byte  (instr),
        .irq_pending (irq_pend),
        .irq_allow   (irq_allow),
        .step_mode   (step_mode),
        .step_go     (step_go),
        .ctrl_word   (ctrl_word),
        .upc         (upc),
        .reg_sel     (reg_sel)
    );

    // Drive inputs for the next edge and queue the state expected after it.
    task automatic drive(input logic [7:0] b, input logic pend, input logic allow,
                         input logic sm, input logic sg, input logic rst,
                         input logic [8:0] eu, input logic [31:0] ec,
                         input logic [1:0] er, input string t);
        exp_t e;
        @(negedge clk);
        #1;
        instr = b; irq_pend = pend; irq_allow = allow;
        step_mode = sm; step_go = sg; rst_n = rst;
        e.u = eu; e.c = ec; e.r = er; e.tag = t;
        sb.push_back(e);
    endtask

    // Monitor: compare one queued expectation per falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (upc !== e.u || ctrl_word !== e.c || reg_sel !== e.r) begin
                n_fail++;
                $display("FAIL %s: upc=%0d cw=%h rs=%0d, expected upc=%0d cw=%h rs=%0d",
                         e.tag, upc, ctrl_word, reg_sel, e.u, e.c, e.r);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 and R2: reset state and the fetch word
        n_chk++;
        if (upc !== 9'd0 || ctrl_word !== FETCH || reg_sel !== 2'd0) begin
            n_fail++;
            $display("FAIL R1/R2 reset: upc=%0d cw=%h rs=%0d, expected upc=0 cw=%h rs=0",
                     upc, ctrl_word, reg_sel, FETCH);
        end

        // R3: byte 22h decodes to word 64, register field 2
        drive(8'h22, 0, 0, 0, 0, 1, 9'd64, 32'h5, 2'd2, "R3 decode 22h");
        drive(8'h22, 0, 0, 0, 0, 1, 9'd65, 32'h8, 2'd2, "R4 movi step");
        drive(8'h22, 0, 0, 0, 0, 1, 9'd66, POLL, 2'd2, "R4 movi to poll");
        drive(8'h0C, 0, 0, 0, 0, 1, 9'd0, FETCH, 2'd2, "R6 poll idle");
        // opcode 3 with an interrupt taken
        drive(8'h0C, 0, 0, 0, 0, 1, 9'd24, 32'h30, 2'd0, "R3 decode 0Ch");
        drive(8'h0C, 1, 1, 0, 0, 1, 9'd25, POLL, 2'd0, "R4 add to poll");
        drive(8'h0C, 1, 1, 0, 0, 1, 9'd26, ACK1, 2'd0, "R6 ack taken");
        drive(8'h0C, 0, 0, 0, 0, 1, 9'd27, ACK2, 2'd0, "R6 ack2");
        drive(8'h31, 0, 0, 0, 0, 1, 9'd28, ACK3, 2'd0, "R6 eoi");
        drive(8'h31, 0, 0, 0, 0, 1, 9'd0, FETCH, 2'd0, "R5 return after eoi");
        // two-slot routine, crossing word 103 to 104
        drive(8'h31, 0, 0, 0, 0, 1, 9'd96, LONGW, 2'd1, "R3 decode 31h");
        for (int k = 97; k <= 107; k++) begin
            drive(8'h31, 0, 0, 0, 0, 1, 9'(k), LONGW, 2'd1, "R4 long routine");
        end
        drive(8'h31, 1, 0, 0, 0, 1, 9'd108, POLL, 2'd1, "R4 long to poll");
        drive(8'h7E, 1, 0, 0, 0, 1, 9'd0, FETCH, 2'd1, "R6 masked request");
        // R9: unassigned opcode 31
        drive(8'h7E, 0, 0, 0, 0, 1, 9'd248, POLL, 2'd2, "R9 bare poll entry");
        drive(8'h03, 0, 0, 0, 0, 1, 9'd0, FETCH, 2'd2, "R9 back to fetch");
        // R8: opcode 0 fetches again
        drive(8'h03, 0, 0, 0, 0, 1, 9'd0, FETCH, 2'd3, "R8 opcode 0 refetch");
        // R7: single-step gating
        drive(8'h21, 0, 0, 1, 0, 1, 9'd0, FETCH, 2'd3, "R7 hold no strobe");
        drive(8'h21, 0, 0, 1, 0, 1, 9'd0, FETCH, 2'd3, "R7 hold no strobe");
        drive(8'h21, 0, 0, 1, 1, 1, 9'd64, 32'h5, 2'd1, "R7 strobed decode");
        drive(8'h21, 0, 0, 1, 0, 1, 9'd64, 32'h5, 2'd1, "R7 hold");
        drive(8'h21, 0, 0, 1, 1, 1, 9'd65, 32'h8, 2'd1, "R7 strobed step");
        drive(8'h21, 0, 0, 1, 1, 1, 9'd66, POLL, 2'd1, "R7 strobed step");
        // poll held with request pending, request gone at the strobe
        drive(8'h21, 1, 1, 1, 0, 1, 9'd66, POLL, 2'd1, "R7 poll held");
        drive(8'h20, 0, 1, 1, 1, 1, 9'd0, FETCH, 2'd1, "R7/R6 poll judged at strobe");
        // R1: reset over a live decode word
        drive(8'h20, 0, 0, 0, 0, 0, 9'd0, FETCH, 2'd0, "R1 reset over decode");
        drive(8'h20, 0, 0, 0, 0, 1, 9'd64, 32'h5, 2'd0, "R3 decode after reset");
        drive(8'h20, 0, 0, 0, 0, 1, 9'd65, 32'h8, 2'd0, "R4 step");
        drive(8'h20, 0, 0, 0, 0, 1, 9'd66, POLL, 2'd0, "R4 step");
        drive(8'h20, 0, 0, 0, 0, 1, 9'd0, FETCH, 2'd0, "R6 poll idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule